// File: doc/BRIEF.md
# Staged Calibration Trigger

This block keeps a small control word (a start bit and a two-bit divide select) in two copies. Bus writes land in a staging copy. The live copy, which drives the rest of the block, takes the staged value only after software writes a commit strobe. A commit flag records each pending commit and clears itself once the copy has been made.

A calibration run begins only when the live start bit goes from 0 to 1. To begin a run, software first commits the bit at 0 and then commits it at 1. The run needs a reference that is present and a two-bit holdover field of 00; if either condition fails at the rising edge, the run is refused and an error flag is raised. While a run is active, a divider derives a calibration tick from the reference clock at a ratio chosen by the live divide select. The tuning work itself is modelled as a fixed number of these ticks, after which a done flag is set. Clearing the live start bit abandons the run and discards the done status.

Top module: `cal_stage_ctrl`

## Requirements
- R1: After reset, the live start bit is 0, the live divide select is 11, and the busy, done, error and commit flags are all 0.
- R2: A write to address 0 (data bit 0 = start, bits 2:1 = divide select) changes only the staged copy. The live outputs keep their values until a commit.
- R3: Writing 1 in data bit 0 to address 1 sets the commit flag on that clock edge. On the next edge the staged copy moves into the live copy and the flag returns to 0, so the flag is high for exactly one cycle.
- R4: While busy, the calibration tick is a one-cycle pulse every 2, 4, 8 or 16 reference cycles for divide select 00, 01, 10 or 11. The first tick comes that many cycles after busy rises.
- R5: A run starts only on a 0 to 1 change of the live start bit. A staged start bit with no commit, or a commit that keeps the live bit at 1, starts nothing.
- R6: An accepted run keeps busy high for exactly CAL_TICKS ticks, that is CAL_TICKS times the ratio in cycles, and then sets done.
- R7: If the reference is absent, or the holdover field is not 00, when the live start bit rises, busy stays 0 and the error flag is set.
- R8: When the live start bit is 0, busy and done go to 0 on the next edge. A run in progress is abandoned.
- R9: An accepted start clears the error flag on the edge that raises busy.
- R10: The calibration tick is 0 whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control word, 1 = commit strobe |
| wr_data | input | SEL_W+1 | Write data |
| ref_present | input | 1 | Reference present indication |
| hold_en | input | 2 | Holdover enable field, must be 00 to calibrate |
| act_start | output | 1 | Live start bit |
| act_div_sel | output | SEL_W | Live divide select |
| upd_flag | output | 1 | Commit pending flag |
| cal_tick | output | 1 | Divided calibration tick |
| cal_busy | output | 1 | Calibration running |
| cal_done | output | 1 | Calibration finished |
| cal_err | output | 1 | Last start was refused |

## Verification
The bench builds the block with CAL_TICKS set to 3 and SEL_W left at 2. With these values, a full run at every divide ratio takes at most 48 cycles, so each ratio's busy length, tick spacing and first-tick position can be measured cycle by cycle. The short runs also leave room to abandon a run part-way, to try refused starts with the reference absent and with holdover set, and to commit the start bit at 1 again to show that it does not restart.

// File: rtl/cal_stage_pkg.sv
package cal_stage_pkg;

   // bus register map
   localparam logic ADDR_CTRL = 1'b0;
   localparam logic ADDR_COMMIT = 1'b1;

   // divide ratio for a select value: 2^(sel+1)
   function automatic int unsigned ratio_of(input int unsigned sel);
      return 32'd2 << sel;
   endfunction

endpackage

// File: rtl/cal_regs.sv
module cal_regs
   import cal_stage_pkg::*;
#(
   parameter int unsigned SEL_W = 2,
   parameter logic [SEL_W-1:0] DEF_DIV_SEL = '1,
   localparam int unsigned CTRL_W = SEL_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [CTRL_W-1:0] wr_data,
   output logic              act_start,
   output logic [SEL_W-1:0]  act_div_sel,
   output logic              upd_flag
);

   logic             stg_start;
   logic [SEL_W-1:0] stg_sel;
   logic             ctrl_wr;
   logic             commit_wr;

   assign ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
   assign commit_wr = wr_en && (wr_addr == ADDR_COMMIT) && wr_data[0];

   // staging copy
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_start <= 1'b0;
         stg_sel   <= DEF_DIV_SEL;
      end else if (ctrl_wr) begin
         stg_start <= wr_data[0];
         stg_sel   <= wr_data[CTRL_W-1:1];
      end
   end

   // live copy and self-clearing commit flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_start   <= 1'b0;
         act_div_sel <= DEF_DIV_SEL;
         upd_flag    <= 1'b0;
      end else begin
         if (upd_flag) begin
            act_start   <= stg_start;
            act_div_sel <= stg_sel;
            upd_flag    <= 1'b0;
         end
         if (commit_wr) begin
            upd_flag <= 1'b1;
         end
      end
   end

   // R2
   live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_flag |=> ($stable(act_start) && $stable(act_div_sel)));

   // R3
   commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_flag && !commit_wr) |=> !upd_flag);

   // R3
   commit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_wr |=> upd_flag);

endmodule

// File: rtl/cal_div.sv
module cal_div
   import cal_stage_pkg::*;
#(
   parameter int unsigned SEL_W = 2,
   localparam int unsigned NRAT = 1 << SEL_W,
   localparam int unsigned MAX_RATIO = 2 << (NRAT - 1),
   localparam int unsigned CNT_W = $clog2(MAX_RATIO)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);

   initial begin
      if (SEL_W < 1 || SEL_W > 3)
         $error("cal_div: SEL_W must be 1 to 3");
   end

   logic [CNT_W-1:0] cnt;
   logic [NRAT-1:0]  term_vec;
   logic             term;

   // one terminal-count decode per selectable ratio
   for (genvar i = 0; i < NRAT; i++) begin : g_term
      localparam int unsigned LAST = ratio_of(i) - 1;
      assign term_vec[i] = (cnt == CNT_W'(LAST));
   end

   assign term = term_vec[sel];
   assign tick = run && term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || term) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R10
   tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> run);

   // R4
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/cal_seq.sv
module cal_seq #(
   parameter int unsigned CAL_TICKS = 32,
   parameter int unsigned HOLD_W = 2,
   localparam int unsigned TW = $clog2(CAL_TICKS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_start,
   input  logic              ref_present,
   input  logic [HOLD_W-1:0] hold_en,
   input  logic              tick,
   output logic              busy,
   output logic              done,
   output logic              err
);

   initial begin
      if (CAL_TICKS < 1)
         $error("cal_seq: CAL_TICKS must be at least 1");
      if (HOLD_W < 1)
         $error("cal_seq: HOLD_W must be at least 1");
   end

   logic          start_q;
   logic          rise;
   logic          cond_ok;
   logic [TW-1:0] tcnt;

   assign rise    = act_start && !start_q;
   assign cond_ok = ref_present && (hold_en == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
      end else begin
         start_q <= act_start;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         err  <= 1'b0;
         tcnt <= '0;
      end else if (!act_start) begin
         busy <= 1'b0;
         done <= 1'b0;
         tcnt <= '0;
      end else if (rise) begin
         if (cond_ok) begin
            busy <= 1'b1;
            done <= 1'b0;
            err  <= 1'b0;
         end else begin
            err <= 1'b1;
         end
         tcnt <= '0;
      end else if (busy && tick) begin
         if (tcnt == TW'(CAL_TICKS - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
            tcnt <= '0;
         end else begin
            tcnt <= tcnt + 1'b1;
         end
      end
   end

   // R6
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   // R6
   done_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));

   // R7
   refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !cond_ok) |=> (err && !busy));

   // R9
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && cond_ok) |=> (busy && !err));

   // R8
   abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !act_start |=> (!busy && !done));

   // R5
   no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !rise) |=> !busy);

endmodule

// File: rtl/cal_stage_ctrl.sv
module cal_stage_ctrl #(
   parameter int unsigned SEL_W = 2,
   parameter int unsigned CAL_TICKS = 32,
   parameter int unsigned HOLD_W = 2,
   localparam int unsigned CTRL_W = SEL_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              ref_present,
   input  logic [HOLD_W-1:0] hold_en,
   output logic              act_start,
   output logic [SEL_W-1:0]  act_div_sel,
   output logic              upd_flag,
   output logic              cal_tick,
   output logic              cal_busy,
   output logic              cal_done,
   output logic              cal_err
);

   cal_regs #(
      .SEL_W       (SEL_W),
      .DEF_DIV_SEL ({SEL_W{1'b1}})
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .act_start   (act_start),
      .act_div_sel (act_div_sel),
      .upd_flag    (upd_flag)
   );

   cal_div #(
      .SEL_W (SEL_W)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (cal_busy),
      .sel   (act_div_sel),
      .tick  (cal_tick)
   );

   cal_seq #(
      .CAL_TICKS (CAL_TICKS),
      .HOLD_W    (HOLD_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .act_start   (act_start),
      .ref_present (ref_present),
      .hold_en     (hold_en),
      .tick        (cal_tick),
      .busy        (cal_busy),
      .done        (cal_done),
      .err         (cal_err)
   );

endmodule

// File: tb/sim_cal_stage_ctrl.sv
module sim_cal_stage_ctrl;

   localparam int unsigned SEL_W = 2;
   localparam int unsigned TICKS = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic wr_addr = 1'b0;
   logic [SEL_W:0] wr_data = '0;
   logic ref_present = 1'b1;
   logic [1:0] hold_en = 2'b00;
   logic act_start, upd_flag, cal_tick, cal_busy, cal_done, cal_err;
   logic [SEL_W-1:0] act_div_sel;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   cal_stage_ctrl #(.SEL_W(SEL_W), .CAL_TICKS(TICKS), .HOLD_W(2)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ref_present(ref_present), .hold_en(hold_en),
      .act_start(act_start), .act_div_sel(act_div_sel), .upd_flag(upd_flag),
      .cal_tick(cal_tick), .cal_busy(cal_busy), .cal_done(cal_done),
      .cal_err(cal_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic addr, input logic [SEL_W:0] data);
      wr_en = 1'b1; wr_addr = addr; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // stage a control word, commit it, and wait for the live copy
   task automatic set_ctrl(input logic [SEL_W-1:0] sel, input logic start);
      bus_write(1'b0, {sel, start});
      bus_write(1'b1, 1);
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk(act_start == 1'b0, "R1 start", int'(act_start), 0);
      chk(act_div_sel == 2'b11, "R1 sel", int'(act_div_sel), 3);
      chk({cal_busy, cal_done, cal_err, upd_flag} == 4'b0, "R1 flags",
          int'({cal_busy, cal_done, cal_err, upd_flag}), 0);
   endtask

   task automatic t_staging();
      bus_write(1'b0, 3'b000);
      chk(act_div_sel == 2'b11, "R2 live sel unchanged", int'(act_div_sel), 3);
      repeat (3) @(negedge clk);
      chk(act_div_sel == 2'b11, "R2 live sel still held", int'(act_div_sel), 3);
      chk(upd_flag == 1'b0, "R2 no commit pending", int'(upd_flag), 0);
      bus_write(1'b1, 1);
      chk(upd_flag == 1'b1, "R3 commit flag set", int'(upd_flag), 1);
      chk(act_div_sel == 2'b11, "R3 live before copy", int'(act_div_sel), 3);
      @(negedge clk);
      chk(upd_flag == 1'b0, "R3 commit flag cleared", int'(upd_flag), 0);
      chk(act_div_sel == 2'b00, "R3 live after copy", int'(act_div_sel), 0);
   endtask

   task automatic t_run(input logic [SEL_W-1:0] sel);
      int ratio = 2 << sel;
      int busy_n = 0, tick_n = 0, first = 0, idle_tick = 0;
      set_ctrl(sel, 1'b0);
      @(negedge clk);
      chk(!cal_busy && !cal_done, "R8 cleared before run",
          int'({cal_busy, cal_done}), 0);
      set_ctrl(sel, 1'b1);
      chk(cal_busy == 1'b0, "R5 busy after edge only", int'(cal_busy), 0);
      for (int i = 1; i <= 16 * TICKS + 10; i++) begin
         @(negedge clk);
         if (cal_busy) begin
            busy_n++;
            if (cal_tick) begin
               tick_n++;
               if (first == 0) first = busy_n;
            end
         end else if (cal_tick) begin
            idle_tick++;
         end
      end
      chk(first == ratio, "R4 first tick position", first, ratio);
      chk(tick_n == TICKS, "R6 tick count", tick_n, TICKS);
      chk(busy_n == TICKS * ratio, "R6 busy length", busy_n, TICKS * ratio);
      chk(cal_done == 1'b1, "R6 done set", int'(cal_done), 1);
      chk(cal_err == 1'b0, "R9 no error", int'(cal_err), 0);
      chk(idle_tick == 0, "R10 no idle tick", idle_tick, 0);
   endtask

   task automatic t_no_restart();
      set_ctrl(2'b00, 1'b1);
      repeat (4) @(negedge clk);
      chk(cal_busy == 1'b0, "R5 recommit at 1 no run", int'(cal_busy), 0);
      chk(cal_done == 1'b1, "R5 done kept", int'(cal_done), 1);
      set_ctrl(2'b00, 1'b0);
      bus_write(1'b0, 3'b001);
      repeat (10) @(negedge clk);
      chk(cal_busy == 1'b0, "R5 staged start ignored", int'(cal_busy), 0);
      chk(act_start == 1'b0, "R5 live start still 0", int'(act_start), 0);
   endtask

   task automatic t_refuse(input logic refp, input logic [1:0] hold, input string tag);
      ref_present = refp; hold_en = hold;
      set_ctrl(2'b00, 1'b0);
      set_ctrl(2'b00, 1'b1);
      @(negedge clk);
      chk(cal_err == 1'b1, {"R7 err ", tag}, int'(cal_err), 1);
      chk(cal_busy == 1'b0, {"R7 no busy ", tag}, int'(cal_busy), 0);
      ref_present = 1'b1; hold_en = 2'b00;
      repeat (6) @(negedge clk);
      chk(cal_busy == 1'b0, {"R5 no late start ", tag}, int'(cal_busy), 0);
   endtask

   task automatic t_err_clear();
      set_ctrl(2'b00, 1'b0);
      set_ctrl(2'b00, 1'b1);
      @(negedge clk);
      chk(cal_busy == 1'b1, "R9 busy on accept", int'(cal_busy), 1);
      chk(cal_err == 1'b0, "R9 err cleared", int'(cal_err), 0);
   endtask

   task automatic t_abandon();
      set_ctrl(2'b11, 1'b0);
      set_ctrl(2'b11, 1'b1);
      repeat (5) @(negedge clk);
      chk(cal_busy == 1'b1, "R8 running before clear", int'(cal_busy), 1);
      set_ctrl(2'b11, 1'b0);
      @(negedge clk);
      chk(cal_busy == 1'b0, "R8 busy dropped", int'(cal_busy), 0);
      repeat (60) @(negedge clk);
      chk(cal_done == 1'b0, "R8 no done after abandon", int'(cal_done), 0);
      chk(cal_tick == 1'b0, "R10 tick idle", int'(cal_tick), 0);
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 50000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
            report();
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_staging();
      for (int s = 0; s < 4; s++) t_run(s[SEL_W-1:0]);
      t_no_restart();
      t_refuse(1'b0, 2'b00, "ref absent");
      t_refuse(1'b1, 2'b01, "holdover");
      t_err_clear();
      t_abandon();
      report();
   end

endmodule